// File: doc/BRIEF.md
# Byte-Wide Decoded-Select Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for byte operands. Two data operands, a carry input and a three-bit operation select enter the block. The select is decoded one-hot, so that at most one of seven function units places its value on a shared result bus: an adder, a right shifter, a left shifter, an inverter, and bitwise AND, OR and XOR units. The carry input takes part only in the adder and the two shifters. The carry output is also taken only from the adder and the two shifters.

Beside the result, the block always reports three flags. One flag marks a result of all zeros. The other two give an unsigned greater-than and an equality comparison of the two operands. The comparison flags do not depend on the select. One select value enables no unit at all. With that value the result bus stays cleared and only the comparison flags carry information. The block has no state, so a caller reads the outputs in the same cycle in which it applies the inputs.

Top module: `alu8_decoded`

## Requirements
- R1: Select codes are 000 add, 001 shift right, 010 shift left, 011 invert, 100 AND, 101 OR, 110 XOR and 111 compare-only. At most one function unit drives the result, and it is the unit named by the select.
- R2: For select 000 the result is the low 8 bits of a + b + carry_in, and carry_out is bit 8 of that sum.
- R3: For select 010 the result is {a[6:0], carry_in} and carry_out is a[7]. For example, a = 10001000 with carry_in 0 gives 00010000 and carry_out 1.
- R4: For select 001 the result is {carry_in, a[7:1]} and carry_out is a[0].
- R5: For select 011 the result is the bitwise inverse of a. For example, 10001000 gives 01110111. Operand b and carry_in have no effect, and carry_out is 0.
- R6: For selects 100, 101 and 110 the result is a AND b, a OR b or a XOR b respectively. carry_in has no effect, and carry_out is 0.
- R7: For select 111 the result is 00000000, carry_out is 0 and zero_flag is 1.
- R8: zero_flag is 1 exactly when the result is 00000000, for every select.
- R9: a_gt_flag is 1 exactly when a > b taken as unsigned values, for every select.
- R10: eq_flag is 1 exactly when a == b, for every select. a_gt_flag and eq_flag are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand; the only operand used by the shifters and the inverter |
| b_in | input | 8 | Second operand |
| carry_in | input | 1 | Added at the LSB for add; the bit moved in for the shifts |
| op_sel | input | 3 | Operation select (see R1) |
| result | output | 8 | Shared result bus |
| carry_out | output | 1 | Carry or shifted-out bit from add and the shifts, else 0 |
| zero_flag | output | 1 | Result equals zero |
| a_gt_flag | output | 1 | a_in greater than b_in, unsigned |
| eq_flag | output | 1 | a_in equal to b_in |

## Verification
The bench sweeps every value of a against a spread of b values, including b equal to a and the extremes 0 and 255, over all eight selects and both carry values. It then adds directed cases. The adder is driven to wrap from 255 + 0 + 1 to zero with a carry. A design that dropped carry_in or took the carry from the wrong bit would return 255 with no carry and a cleared zero flag. For the shifts, the bench checks which end the carry enters at and which end the carry leaves from. A swapped or mirrored shifter would put the inserted bit at the wrong end. Other directed cases toggle b and carry_in under the invert and bitwise selects and look for any change on the outputs. A final case confirms that the compare-only select still clears the bus and reports comparisons. A decoder that let a unit leak through on that select would give a nonzero result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int OP_W    = 3;
    localparam int N_UNITS = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SHR = 3'd1,
        OP_SHL = 3'd2,
        OP_NOT = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;
endpackage

// File: rtl/alu8_op_decoder.sv
module alu8_op_decoder
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]    op_sel,
    output logic [N_UNITS-1:0] unit_en
);
    for (genvar u = 0; u < N_UNITS; u++) begin : g_dec
        assign unit_en[u] = (op_sel == OP_W'(u));
    end
endmodule

// File: rtl/alu8_units.sv
module alu8_units
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]  a_in,
    input  logic [DATA_W-1:0]  b_in,
    input  logic               carry_in,
    input  logic [N_UNITS-1:0] unit_en,
    output logic [DATA_W-1:0]  bus_out,
    output logic               carry_out
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] unit_res [N_UNITS];
    logic [N_UNITS-1:0] unit_co;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        if (u == int'(OP_ADD)) begin : g_add
            logic [SUM_W-1:0] sum;
            assign sum = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, carry_in};
            assign unit_res[u] = sum[DATA_W-1:0];
            assign unit_co[u]  = sum[DATA_W];
        end else if (u == int'(OP_SHR)) begin : g_shr
            assign unit_res[u] = {carry_in, a_in[DATA_W-1:1]};
            assign unit_co[u]  = a_in[0];
        end else if (u == int'(OP_SHL)) begin : g_shl
            assign unit_res[u] = {a_in[DATA_W-2:0], carry_in};
            assign unit_co[u]  = a_in[DATA_W-1];
        end else if (u == int'(OP_NOT)) begin : g_not
            assign unit_res[u] = ~a_in;
            assign unit_co[u]  = 1'b0;
        end else if (u == int'(OP_AND)) begin : g_and
            assign unit_res[u] = a_in & b_in;
            assign unit_co[u]  = 1'b0;
        end else if (u == int'(OP_OR)) begin : g_or
            assign unit_res[u] = a_in | b_in;
            assign unit_co[u]  = 1'b0;
        end else begin : g_xor
            assign unit_res[u] = a_in ^ b_in;
            assign unit_co[u]  = 1'b0;
        end
    end

    always_comb begin
        bus_out   = '0;
        carry_out = 1'b0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (unit_en[u]) begin
                bus_out   = bus_out | unit_res[u];
                carry_out = carry_out | unit_co[u];
            end
        end
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] bus_in,
    output logic              zero_flag,
    output logic              a_gt_flag,
    output logic              eq_flag
);
    assign zero_flag = ~(|bus_in);
    assign a_gt_flag = (a_in > b_in);
    assign eq_flag   = (a_in == b_in);
endmodule

// File: rtl/alu8_decoded.sv
module alu8_decoded
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              carry_in,
    input  logic [OP_W-1:0]   op_sel,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              zero_flag,
    output logic              a_gt_flag,
    output logic              eq_flag
);
    logic [N_UNITS-1:0] unit_en;

    alu8_op_decoder u_dec (
        .op_sel  (op_sel),
        .unit_en (unit_en)
    );

    alu8_units #(.DATA_W(DATA_W)) u_units (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .unit_en   (unit_en),
        .bus_out   (result),
        .carry_out (carry_out)
    );

    alu8_flags #(.DATA_W(DATA_W)) u_flags (
        .a_in      (a_in),
        .b_in      (b_in),
        .bus_in    (result),
        .zero_flag (zero_flag),
        .a_gt_flag (a_gt_flag),
        .eq_flag   (eq_flag)
    );
endmodule

// File: rtl/alu8_decoded_chk.sv
module alu8_decoded_chk #(
    parameter int DATA_W = 8
) (
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] b_in,
    input logic              carry_in,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              zero_flag,
    input logic              a_gt_flag,
    input logic              eq_flag
);
    logic known;
    assign known = !$isunknown({a_in, b_in, carry_in, op_sel});

    always_comb begin
        if (known) begin
            if (op_sel == 3'd7) begin
                AST_CMP_BUS_CLEAR: assert (result == '0 && carry_out == 1'b0) else $error("compare select drove bus"); // R7
            end
            AST_ZERO_TRACKS_BUS: assert (zero_flag == (result == '0)) else $error("zero flag mismatch"); // R8
            AST_CMP_EXCLUSIVE: assert (!(a_gt_flag && eq_flag)) else $error("gt and eq both set"); // R10
            if (op_sel == 3'd2) begin
                AST_SHL_CARRY_MSB: assert (carry_out == a_in[DATA_W-1]) else $error("shl carry wrong"); // R3
            end
            if (op_sel == 3'd3) begin
                AST_NOT_INVERTS: assert (result == ~a_in && !carry_out) else $error("invert wrong"); // R5
            end
            if (op_sel >= 3'd4 && op_sel <= 3'd6) begin
                AST_LOGIC_NO_CARRY: assert (!carry_out) else $error("logic op carry set"); // R6
            end
        end
    end
endmodule

bind alu8_decoded alu8_decoded_chk #(.DATA_W(DATA_W)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .zero_flag (zero_flag),
    .a_gt_flag (a_gt_flag),
    .eq_flag   (eq_flag)
);

// File: tb/alu8_decoded_tb.sv
`timescale 1ns/1ps
module alu8_decoded_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic       carry_in = 1'b0;
    logic [2:0] op_sel = 3'd7;
    logic [7:0] result;
    logic       carry_out, zero_flag, a_gt_flag, eq_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu8_decoded u_dut (
        .a_in (a_in), .b_in (b_in), .carry_in (carry_in), .op_sel (op_sel),
        .result (result), .carry_out (carry_out), .zero_flag (zero_flag),
        .a_gt_flag (a_gt_flag), .eq_flag (eq_flag)
    );

    function automatic string op_req(input int op);
        case (op)
            0: return "R2";
            1: return "R4";
            2: return "R3";
            3: return "R5";
            4, 5, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int ci, input int op);
        @(posedge clk);
        a_in = 8'(a); b_in = 8'(b); carry_in = 1'(ci); op_sel = 3'(op);
        @(negedge clk);
    endtask

    // Reference model computed arithmetically from the requirements.
    task automatic verify(input int a, input int b, input int ci, input int op);
        int ec, eco;
        bit ok;
        string req;
        case (op)
            0: begin ec = (a + b + ci) % 256; eco = (a + b + ci) / 256; end
            1: begin ec = a / 2 + ci * 128; eco = a % 2; end
            2: begin ec = (a * 2) % 256 + ci; eco = a / 128; end
            3: begin ec = 255 - a; eco = 0; end
            4: begin ec = a & b; eco = 0; end
            5: begin ec = a | b; eco = 0; end
            6: begin ec = a ^ b; eco = 0; end
            default: begin ec = 0; eco = 0; end
        endcase
        req = op_req(op);
        ok = (int'(result) == ec) && (int'(carry_out) == eco) &&
             (int'(zero_flag) == int'(ec == 0)) &&
             (int'(a_gt_flag) == int'(a > b)) && (int'(eq_flag) == int'(a == b));
        checks++;
        if (!ok) begin
            failures++;
            if (int'(result) != ec)
                $display("FAIL %s result op=%0d a=%0d b=%0d ci=%0d actual=%0d expected=%0d", req, op, a, b, ci, result, ec);
            if (int'(carry_out) != eco)
                $display("FAIL %s carry op=%0d a=%0d b=%0d ci=%0d actual=%0d expected=%0d", req, op, a, b, ci, carry_out, eco);
            if (int'(zero_flag) != int'(ec == 0))
                $display("FAIL R8 zero op=%0d actual=%0d expected=%0d", op, zero_flag, int'(ec == 0));
            if (int'(a_gt_flag) != int'(a > b))
                $display("FAIL R9 a_gt a=%0d b=%0d actual=%0d expected=%0d", a, b, a_gt_flag, int'(a > b));
            if (int'(eq_flag) != int'(a == b))
                $display("FAIL R10 eq a=%0d b=%0d actual=%0d expected=%0d", a, b, eq_flag, int'(a == b));
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int r0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state: compare-only select with zero operands (R7, R8, R10)
        chk(result == 8'h00 && zero_flag && !carry_out, "R7", "idle result", result, 0);
        chk(eq_flag && !a_gt_flag, "R10", "idle eq", eq_flag, 1);

        // Directed cases
        apply(8'h88, 0, 0, 2);
        chk(result == 8'h10 && carry_out, "R3", "shl 88", result, 16);
        apply(8'h88, 8'h5A, 1, 3);
        chk(result == 8'h77 && !carry_out, "R5", "not 88", result, 119);
        r0 = result;
        apply(8'h88, 8'hA5, 0, 3);
        chk(int'(result) == r0 && !carry_out, "R5", "not ignores b/cin", result, r0);
        apply(8'hFF, 8'h00, 1, 0);
        chk(result == 8'h00 && carry_out && zero_flag, "R2", "add wrap", result, 0);
        chk(zero_flag, "R8", "zero on wrap", zero_flag, 1);
        apply(8'h01, 8'h00, 1, 1);
        chk(result == 8'h80 && carry_out, "R4", "shr cin enters msb", result, 128);
        apply(8'h80, 8'h00, 1, 2);
        chk(result == 8'h01 && carry_out, "R3", "shl cin enters lsb", result, 1);
        apply(8'h0F, 8'h3C, 1, 4);
        chk(result == 8'h0C && !carry_out, "R6", "and ignores cin", result, 12);
        apply(8'h0F, 8'h3C, 1, 5);
        chk(result == 8'h3F && !carry_out, "R6", "or", result, 63);
        apply(8'h0F, 8'h3C, 1, 6);
        chk(result == 8'h33 && !carry_out, "R6", "xor", result, 51);
        apply(5, 3, 1, 7);
        chk(result == 8'h00 && zero_flag && !carry_out, "R7", "compare-only bus", result, 0);
        chk(a_gt_flag && !eq_flag, "R9", "compare-only gt", a_gt_flag, 1);
        apply(3, 5, 0, 0);
        chk(!a_gt_flag && !eq_flag && result == 8'h08, "R1", "add select", result, 8);

        // Near-exhaustive sweep over all selects and carry values (R1..R10)
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 26; bi++) begin
                int b;
                b = (bi < 24) ? bi * 11 : ((bi == 24) ? a : 255);
                for (int op = 0; op < 8; op++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        if (bi % 2 == 0 || op < 4 || ci == 0) begin
                            apply(a, b, ci, op);
                            verify(a, b, ci, op);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule